// File: doc/BRIEF.md
# Reference-Gated Clock Frequency Counter

This block measures how fast an unknown clock runs by counting its rising edges during a window of known length. The window is timed by a down-counter clocked by a trusted reference clock (typically a crystal divided down, a few MHz). Software writes a control word that holds a tick count and a run-enable bit. On the rising edge of the enable, the window opens for exactly that many reference cycles. The open window is carried into the measured-clock domain through a flop synchronizer. There, an edge counter clears itself on the first gated edge and then counts every gated edge.

Once the window closes, the reference side waits for the measured side to report that it is idle again. It then captures the edge count and raises a done flag. The status word packs that flag just above the captured count. A typical routine writes zero, waits for done to read clear, writes the enable with the tick count, polls done, reads the count, and writes zero again.

The measured-side counter is cleared only by logic that runs on the measured clock. If that clock is stopped, the count keeps its old value, and a short run followed by a long run then gives equal results. Software can use this to tell that the clock is off.

Top module: `freqcnt_top`

## Requirements
- R1: After reset the status word reads all zeros: done clear and count zero.
- R2: The control word carries the window length in ticks in bits TICK_W-1:0 and the run-enable in bit TICK_W (bit 20 by default). A 0-to-1 change of the enable loads the tick count, clears done and opens the window for exactly that many reference cycles.
- R3: The measured counter counts the measured-clock rising edges on which the window, after a two-stage synchronizer, is seen open. The first such edge of a run sets the count to 1.
- R4: Done is status bit CNT_W (bit 25 by default). It sets only after the window has closed and the measured side reports idle through a two-stage synchronizer. The count in status bits CNT_W-1:0 is captured at that moment and stays fixed while done is set.
- R5: Writing zero to the control word closes the window, stops the reference counter and clears done within two reference cycles.
- R6: A run started with a tick count of zero counts no edges and still sets done, and the status count keeps its previous value.
- R7: When the measured clock is stopped, a run still sets done, and the reported count equals the result of the previous run.
- R8: The edge count saturates at 2^CNT_W-1 and never wraps.
- R9: Writing the control word again while the enable is already set does not restart the run, and the status word does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; also clocks the register interface |
| ref_rst_n | input | 1 | Synchronous active-low reset, reference domain |
| meas_clk | input | 1 | Clock under measurement |
| meas_rst_n | input | 1 | Synchronous active-low reset, measured domain |
| ctrl_we | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | TICK_W+1 | Control word: enable in the top bit, tick count below it |
| status_word | output | CNT_W+1 | Done flag in the top bit, captured edge count below it |

## Verification
The assertions assume a measured clock that, while it runs, is fast enough that its busy echo comes back to the reference side before the window closes. The window must therefore span more than a few reference cycles whenever the measured clock is active. They also assume that the two clocks never share an edge and that control writes are single-cycle strobes. The stimulus uses a measured clock at 10/7 of the reference rate with phases that never meet, and it uses windows of at least 37 ticks while that clock runs. It stops the measured clock only in its low phase and only between runs, and it uses zero-length windows only where the model predicts no gated edge.

// File: rtl/freqcnt_pkg.sv
// Package: shared types for the frequency counter.
// Assumes: nothing; holds the reference-side phase encoding only.
package freqcnt_pkg;

    // Phases of one measurement as seen from the reference domain.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,   // enable low, nothing running
        PH_GATE  = 2'd1,   // window open, down-counter running
        PH_WAIT  = 2'd2,   // window closed, waiting for measured side idle
        PH_DONE  = 2'd3    // count captured, done flag set
    } phase_t;

endpackage

// File: rtl/freqcnt_sync.sv
// Module: multi-stage single-bit synchronizer.
// Does: carries a level signal into the clk domain through STAGES flops.
// Assumes: d is a level held for several destination cycles; STAGES >= 2.
module freqcnt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] stage_q;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                // First flop samples the asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[gi] <= 1'b0;
                    else        stage_q[gi] <= d;
                end
            end else begin : g_next
                // Later flops let metastability settle.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[gi] <= 1'b0;
                    else        stage_q[gi] <= stage_q[gi-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/freqcnt_edge_counter.sv
// Module: measured-domain edge counter.
// Does: counts meas_clk edges while the synchronized window is open,
//       restarting at 1 on the first open edge, saturating at all-ones.
//       busy echoes the window one cycle later for the return path.
// Assumes: gate_sync is already synchronized to clk. The count changes
//          only on clk edges, so a stopped clk keeps the last value.
module freqcnt_edge_counter #(
    parameter int CNT_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_sync,
    output logic [CNT_W-1:0] count,
    output logic             busy
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    // Echo of the window, delayed one cycle; falls after the last count.
    always_ff @(posedge clk) begin
        if (!rst_n) busy <= 1'b0;
        else        busy <= gate_sync;
    end

    // Edge counter: restart on window open, count up, hold at max.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (gate_sync && !busy) begin
            count <= CNT_ONE;
        end else if (gate_sync && count != CNT_MAX) begin
            count <= count + CNT_ONE;
        end
    end

endmodule

// File: rtl/freqcnt_ref_timer.sv
// Module: reference-domain control register, window timer and capture.
// Does: holds the control word, starts a window on the enable's rising
//       edge, counts it down, then waits for the measured side to go idle
//       before capturing the count and raising done.
// Assumes: meas_count is stable whenever busy_sync has been low for the
//          synchronizer latency after the window closed.
module freqcnt_ref_timer
    import freqcnt_pkg::*;
#(
    parameter int TICK_W = 20,
    parameter int CNT_W  = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic [TICK_W:0]  ctrl_wdata,
    input  logic             busy_sync,
    input  logic [CNT_W-1:0] meas_count,
    output logic             gate,
    output logic             done,
    output logic [CNT_W-1:0] count_cap
);

    localparam int          EN_BIT   = TICK_W;
    localparam logic [TICK_W-1:0] TICK_ONE = TICK_W'(1);

    logic [TICK_W:0]   ctrl_q;
    logic              en_prev;
    logic [TICK_W-1:0] left_q;
    phase_t            phase_q;
    logic              run_en;
    logic              start;

    assign run_en = ctrl_q[EN_BIT];
    assign start  = run_en && !en_prev;

    // Control register: loaded by a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= ctrl_wdata;
    end

    // Previous enable level for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) en_prev <= 1'b0;
        else        en_prev <= run_en;
    end

    // Window sequencer: load, count down, wait for idle, hold done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            left_q  <= '0;
        end else if (start) begin
            left_q  <= ctrl_q[TICK_W-1:0];
            phase_q <= (ctrl_q[TICK_W-1:0] != '0) ? PH_GATE : PH_WAIT;
        end else if (!run_en) begin
            left_q  <= '0;
            phase_q <= PH_IDLE;
        end else begin
            case (phase_q)
                PH_GATE: begin
                    left_q <= left_q - TICK_ONE;
                    if (left_q == TICK_ONE) phase_q <= PH_WAIT;
                end
                PH_WAIT: begin
                    if (!busy_sync) phase_q <= PH_DONE;
                end
                default: ;
            endcase
        end
    end

    // Capture register: takes the settled count as done rises.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_cap <= '0;
        end else if (run_en && !start && phase_q == PH_WAIT && !busy_sync) begin
            count_cap <= meas_count;
        end
    end

    assign gate = (phase_q == PH_GATE);
    assign done = (phase_q == PH_DONE);

endmodule

// File: rtl/freqcnt_top.sv
// Module: reference-gated clock frequency counter, top level.
// Does: ties the reference timer, the two synchronizers and the measured
//       edge counter together and packs the status word.
// Assumes: ref_clk and meas_clk are unrelated; each reset is synchronous
//          to its own clock and is held while that clock runs.
module freqcnt_top #(
    parameter int TICK_W      = 20,
    parameter int CNT_W       = 25,
    parameter int SYNC_STAGES = 2
) (
    input  logic              ref_clk,
    input  logic              ref_rst_n,
    input  logic              meas_clk,
    input  logic              meas_rst_n,
    input  logic              ctrl_we,
    input  logic [TICK_W:0]   ctrl_wdata,
    output logic [CNT_W:0]    status_word
);

    logic             ref_gate;
    logic             gate_meas;
    logic             busy_meas;
    logic             busy_ref;
    logic [CNT_W-1:0] cnt_meas;
    logic             done_ref;
    logic [CNT_W-1:0] cnt_cap;

    freqcnt_ref_timer #(
        .TICK_W (TICK_W),
        .CNT_W  (CNT_W)
    ) u_timer (
        .clk        (ref_clk),
        .rst_n      (ref_rst_n),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .busy_sync  (busy_ref),
        .meas_count (cnt_meas),
        .gate       (ref_gate),
        .done       (done_ref),
        .count_cap  (cnt_cap)
    );

    freqcnt_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
        .clk   (meas_clk),
        .rst_n (meas_rst_n),
        .d     (ref_gate),
        .q     (gate_meas)
    );

    freqcnt_edge_counter #(.CNT_W(CNT_W)) u_counter (
        .clk       (meas_clk),
        .rst_n     (meas_rst_n),
        .gate_sync (gate_meas),
        .count     (cnt_meas),
        .busy      (busy_meas)
    );

    freqcnt_sync #(.STAGES(SYNC_STAGES)) u_busy_sync (
        .clk   (ref_clk),
        .rst_n (ref_rst_n),
        .d     (busy_meas),
        .q     (busy_ref)
    );

    assign status_word = {done_ref, cnt_cap};

endmodule

// File: rtl/freqcnt_checker.sv
// Module: assertion checker for freqcnt_top, attached by bind.
// Assumes: the measured clock, when running, echoes busy before the
//          window closes; see the brief.
module freqcnt_checker #(
    parameter int TICK_W = 20,
    parameter int CNT_W  = 25
) (
    input logic             ref_clk,
    input logic             ref_rst_n,
    input logic             meas_clk,
    input logic             meas_rst_n,
    input logic             ctrl_we,
    input logic [TICK_W:0]  ctrl_wdata,
    input logic [CNT_W:0]   status_word,
    input logic             ref_gate,
    input logic             busy_ref,
    input logic             gate_meas,
    input logic [CNT_W-1:0] cnt_meas
);

    // R4: a captured count does not move while done stays set.
    a_r4_count_stable: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        status_word[CNT_W] && $past(status_word[CNT_W]) |-> $stable(status_word[CNT_W-1:0]));

    // R4: done rises only with the window closed and after an idle echo.
    a_r4_done_after_idle: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        $rose(status_word[CNT_W]) |-> !ref_gate && !$past(busy_ref));

    // R5: a zero control write clears done two cycles later.
    a_r5_zero_clears: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        ctrl_we && ctrl_wdata == '0 |=> ##1 !status_word[CNT_W] && !ref_gate);

    // R3: no counting on edges where the synchronized window is closed.
    a_r3_hold_closed: assert property (@(posedge meas_clk) disable iff (!meas_rst_n)
        !gate_meas |=> $stable(cnt_meas));

    // R8: the count only holds, steps by one or restarts at one; never wraps.
    a_r8_no_wrap: assert property (@(posedge meas_clk) disable iff (!meas_rst_n)
        1'b1 |=> (cnt_meas == $past(cnt_meas))
              || ({1'b0, cnt_meas} == {1'b0, $past(cnt_meas)} + 1'b1)
              || (cnt_meas == CNT_W'(1)));

endmodule

bind freqcnt_top freqcnt_checker #(
    .TICK_W (TICK_W),
    .CNT_W  (CNT_W)
) u_chk (
    .ref_clk     (ref_clk),
    .ref_rst_n   (ref_rst_n),
    .meas_clk    (meas_clk),
    .meas_rst_n  (meas_rst_n),
    .ctrl_we     (ctrl_we),
    .ctrl_wdata  (ctrl_wdata),
    .status_word (status_word),
    .ref_gate    (ref_gate),
    .busy_ref    (busy_ref),
    .gate_meas   (gate_meas),
    .cnt_meas    (cnt_meas)
);

// File: tb/sim_freqcnt_top.sv
`timescale 1ns/1ps
// Bench: behavioural cycle model of the frequency counter, compared on
// every reference clock, plus directed checks per requirement.
module sim_freqcnt_top;

    localparam real CLK_PERIOD  = 10.0;
    localparam real MEAS_HALF   = 3.5;
    localparam int  TICK_W      = 20;
    localparam int  CNT_W       = 10;
    localparam int  CNT_MAX     = (1 << CNT_W) - 1;
    localparam int  EN          = 1 << TICK_W;
    localparam int  WATCHDOG    = 150000;

    logic              ref_clk = 1'b0;
    logic              meas_clk = 1'b0;
    logic              ref_rst_n = 1'b0;
    logic              meas_rst_n = 1'b0;
    logic              ctrl_we = 1'b0;
    logic [TICK_W:0]   ctrl_wdata = '0;
    logic [CNT_W:0]    status_word;
    bit                meas_run = 1'b1;

    int checks = 0;
    int errors = 0;
    int ref_cycles = 0;
    bit compare_on = 1'b0;

    freqcnt_top #(.TICK_W(TICK_W), .CNT_W(CNT_W), .SYNC_STAGES(2)) u0 (
        .ref_clk     (ref_clk),
        .ref_rst_n   (ref_rst_n),
        .meas_clk    (meas_clk),
        .meas_rst_n  (meas_rst_n),
        .ctrl_we     (ctrl_we),
        .ctrl_wdata  (ctrl_wdata),
        .status_word (status_word)
    );

    always #(CLK_PERIOD / 2.0) ref_clk = ~ref_clk;

    // Measured clock; when stopped it parks low.
    initial begin
        #0.25;
        forever begin
            #(MEAS_HALF);
            if (meas_run || meas_clk) meas_clk = ~meas_clk;
        end
    end

    // ---------------- behavioural model ----------------
    int m_ctrl = 0;
    bit m_en_d = 0;
    int m_left = 0;
    int m_phase = 0;       // 0 idle, 1 window, 2 wait, 3 done
    int m_cap = 0;
    int m_mcnt = 0;
    bit m_busy = 0;
    bit qb[$] = '{1'b0, 1'b0};
    bit qg[$] = '{1'b0, 1'b0};

    always @(posedge ref_clk) begin
        if (!ref_rst_n) begin
            m_ctrl = 0; m_en_d = 0; m_left = 0; m_phase = 0; m_cap = 0;
            qb = '{1'b0, 1'b0};
        end else begin
            bit b_old;
            bit en;
            bit st;
            qb.push_front(m_busy);
            b_old = qb.pop_back();
            en = (m_ctrl & EN) != 0;
            st = en && !m_en_d;
            if (st) begin
                m_left  = m_ctrl & (EN - 1);
                m_phase = (m_left != 0) ? 1 : 2;
            end else if (!en) begin
                m_left = 0; m_phase = 0;
            end else if (m_phase == 1) begin
                if (m_left == 1) m_phase = 2;
                m_left = m_left - 1;
            end else if (m_phase == 2 && !b_old) begin
                m_phase = 3; m_cap = m_mcnt;
            end
            m_en_d = en;
            if (ctrl_we) m_ctrl = int'(ctrl_wdata);
        end
    end

    always @(posedge meas_clk) begin
        if (!meas_rst_n) begin
            m_mcnt = 0; m_busy = 0; qg = '{1'b0, 1'b0};
        end else begin
            bit g_old;
            qg.push_front(m_phase == 1);
            g_old = qg.pop_back();
            if (g_old) begin
                if (!m_busy) m_mcnt = 1;
                else if (m_mcnt < CNT_MAX) m_mcnt = m_mcnt + 1;
            end
            m_busy = g_old;
        end
    end

    // Every-cycle comparison against the model (R2, R3, R4).
    always @(negedge ref_clk) begin
        ref_cycles++;
        if (compare_on) begin
            int exp_w;
            exp_w = ((m_phase == 3) ? (1 << CNT_W) : 0) | m_cap;
            checks++;
            if (int'(status_word) != exp_w) begin
                errors++;
                $display("FAIL R4 status model cycle %0d: actual %h expected %h",
                         ref_cycles, status_word, exp_w);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int data);
        @(negedge ref_clk);
        ctrl_we = 1'b1;
        ctrl_wdata = data[TICK_W:0];
        @(negedge ref_clk);
        ctrl_we = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n;
        n = 0;
        while (!status_word[CNT_W] && n < 5000) begin
            @(negedge ref_clk);
            n++;
        end
        check(req, int'(status_word[CNT_W]), 1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge ref_clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        wait (ref_cycles >= WATCHDOG);
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected below %0d", ref_cycles, WATCHDOG);
        finish_run();
    end

    // ---------------- stimulus ----------------
    initial begin
        int prev;
        int cnt;
        idle(4);
        ref_rst_n  = 1'b1;
        meas_rst_n = 1'b1;
        // R1: reset state.
        check("R1 reset status", int'(status_word), 0);
        compare_on = 1'b1;

        // R2/R3/R4: 100-tick window, clock ratio 10/7.
        wr(EN | 100);
        idle(1);
        check("R2 done clear after start", int'(status_word[CNT_W]), 0);
        wait_done("R4 done after window");
        cnt = int'(status_word[CNT_W-1:0]);
        checks++;
        if (cnt < 140 || cnt > 146) begin
            errors++;
            $display("FAIL R3 count: actual %0d expected 140..146", cnt);
        end

        // R9: rewrite with enable still set; nothing changes.
        prev = int'(status_word);
        wr(EN | 5);
        idle(30);
        check("R9 no restart", int'(status_word), prev);

        // R5: zero write clears done.
        wr(0);
        idle(1);
        check("R5 done cleared", int'(status_word[CNT_W]), 0);
        idle(8);

        // R2/R3: second window of 37 ticks.
        wr(EN | 37);
        wait_done("R4 done 37");
        cnt = int'(status_word[CNT_W-1:0]);
        checks++;
        if (cnt < 51 || cnt > 55) begin
            errors++;
            $display("FAIL R3 count 37: actual %0d expected 51..55", cnt);
        end
        prev = cnt;
        wr(0);
        idle(8);

        // R6: zero-tick window.
        wr(EN | 0);
        wait_done("R6 done zero ticks");
        check("R6 count held", int'(status_word[CNT_W-1:0]), prev);
        wr(0);
        idle(8);

        // R7: stopped measured clock.
        meas_run = 1'b0;
        idle(4);
        wr(EN | 60);
        wait_done("R7 done stopped clock");
        check("R7 count held", int'(status_word[CNT_W-1:0]), prev);
        wr(0);
        idle(4);
        meas_run = 1'b1;
        idle(10);

        // R8: saturation.
        wr(EN | 800);
        wait_done("R8 done long window");
        check("R8 saturated", int'(status_word[CNT_W-1:0]), CNT_MAX);
        wr(0);
        idle(6);
        check("R5 done cleared again", int'(status_word[CNT_W]), 0);

        finish_run();
    end

endmodule